// File: doc/BRIEF.md
# Debug Control Register Scan Access

This block is a JTAG test data register through which an external debugger reads a processor's 32-bit debug control and status register and rewrites part of it. It becomes active when its own 5-bit instruction sits in the JTAG instruction register. A 36-bit chain clocked by TCK captures the register image and shifts it out on TDO while a new image shifts in from TDI. On Update-DR the chain is copied into an update register, and the copy is handed to the core clock domain.

Two request bits ride in the chain below the register image. One asks for an external debug break, which the core side turns into a single-cycle pulse. The other holds the core in reset, for instance while code is loaded into the instruction cache. This one is a level that stays set until a later update clears it. The core side writes back only the bits that a write mask enables, and every other bit keeps its current value. The TAP controller supplies the capture, shift, update and test-logic-reset strobes.

Top module: `jtag_dbgreg_access`

## Requirements
- R1: Capture, shift and update act only while `ir_value` equals 5'b01001. Under any other instruction, an update produces no register write, no break pulse and no change of `hold_reset`, and `tdo` is 0.
- R2: Capture-DR loads the chain with bit 35 = 1, bits 34:3 = `core_reg`, and bits 2:0 = 0.
- R3: In each Shift-DR cycle, `tdi` enters at chain bit 35 and the chain moves one place toward bit 0. `tdo` presents chain bit 0, so the captured image leaves least significant bit first.
- R4: Every selected Update-DR gives exactly one `reg_wr_en` pulse. With it comes `reg_wr_data` = (scanned bits 34:3 AND `wr_mask`) OR (`core_reg` AND NOT `wr_mask`).
- R5: When scanned bit 2 is 1, an update gives exactly one single-cycle `dbg_break` pulse in the core clock domain. When bit 2 is 0, no pulse follows.
- R6: `hold_reset` takes scanned bit 1 on each update and keeps that level until a later update or a test-logic-reset.
- R7: Scanned bits 35 and 0 have no effect on `reg_wr_data`, `dbg_break` or `hold_reset`.
- R8: A TCK cycle with `tap_tlr` high clears `hold_reset` and drops any break request that has not yet been delivered. No register write results from it.
- R9: After reset, `tdo`, `reg_wr_en`, `dbg_break` and `hold_reset` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock |
| trst_n | input | 1 | Asynchronous active-low reset of the TCK side |
| tap_tlr | input | 1 | TAP is in Test-Logic-Reset (sampled on TCK) |
| ir_value | input | 5 | Current JTAG instruction register contents |
| capture_dr | input | 1 | TAP Capture-DR strobe |
| shift_dr | input | 1 | TAP Shift-DR strobe |
| update_dr | input | 1 | TAP Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0 while selected) |
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low core reset |
| core_reg | input | 32 | Current debug control/status value from the core |
| wr_mask | input | 32 | 1 marks a bit that JTAG may write |
| reg_wr_en | output | 1 | One-cycle write strobe for the debug register |
| reg_wr_data | output | 32 | Merged value to write |
| dbg_break | output | 1 | One-cycle external debug break pulse |
| hold_reset | output | 1 | Level request to hold the core in reset |

## Verification
Some properties can be checked on every cycle, and assertions cover them. These are the captured constant bits, the one-place shift per Shift-DR cycle, the frozen chain when the instruction does not match, the one-cycle width of the write and break strobes, and the rule that `hold_reset` only moves when a transfer arrives. The masked-bit merge is also checked against the previous cycle's inputs. Other behaviour needs whole scan sequences across both clocks, and only the bench scenarios show it. This covers the full captured image seen on TDO, the count of break pulses per update, the lasting hold level and its clearing, the ignored bits 35 and 0, and the effect of test-logic-reset.

// File: rtl/jtag_dbgreg_pkg.sv
package jtag_dbgreg_pkg;
    localparam int REG_W   = 32;
    localparam int CHAIN_W = REG_W + 4;
    localparam int IMG_LO  = 3;
    localparam int IMG_HI  = IMG_LO + REG_W - 1;
    localparam int BRK_BIT = 2;
    localparam int HLD_BIT = 1;

    typedef struct packed {
        logic [REG_W-1:0] image;
        logic             brk;
        logic             hold;
        logic             wr;
    } xfer_t;
endpackage

// File: rtl/jtag_dbgreg_chain.sv
module jtag_dbgreg_chain
    import jtag_dbgreg_pkg::*;
#(
    parameter int          IR_W       = 5,
    parameter logic [IR_W-1:0] SEL_OPCODE = 5'b01001
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tap_tlr,
    input  logic [IR_W-1:0]  ir_value,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             tdi,
    output logic             tdo,
    input  logic [REG_W-1:0] core_reg,
    output xfer_t            xfer,
    output logic             xfer_tgl
);
    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
        xfer_t              upd;
        logic               tgl;
    } tck_state_t;

    tck_state_t st_d, st_q;
    logic       sel;

    assign sel = (ir_value == SEL_OPCODE);

    always_comb begin
        st_d = st_q;
        if (sel && capture_dr) begin
            st_d.chain                 = '0;
            st_d.chain[CHAIN_W-1]      = 1'b1;
            st_d.chain[IMG_HI:IMG_LO]  = core_reg;
        end else if (sel && shift_dr) begin
            st_d.chain = {tdi, st_q.chain[CHAIN_W-1:1]};
        end
        if (tap_tlr) begin
            st_d.upd.hold = 1'b0;
            st_d.upd.brk  = 1'b0;
            st_d.upd.wr   = 1'b0;
            if (st_q.upd.hold || st_q.upd.brk)
                st_d.tgl = ~st_q.tgl;
        end else if (sel && update_dr) begin
            st_d.upd.image = st_q.chain[IMG_HI:IMG_LO];
            st_d.upd.brk   = st_q.chain[BRK_BIT];
            st_d.upd.hold  = st_q.chain[HLD_BIT];
            st_d.upd.wr    = 1'b1;
            st_d.tgl       = ~st_q.tgl;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tdo      = sel ? st_q.chain[0] : 1'b0;
    assign xfer     = st_q.upd;
    assign xfer_tgl = st_q.tgl;

    // R2
    capture_fixed_bits_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (sel && capture_dr) |=> (st_q.chain[2:0] == 3'b000 && st_q.chain[CHAIN_W-1]));
    // R3
    shift_one_place_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (sel && shift_dr && !capture_dr) |=>
            (st_q.chain == {$past(tdi), $past(st_q.chain[CHAIN_W-1:1])}));
    // R1
    unselected_frozen_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !sel |=> $stable(st_q.chain));
    // R1
    unselected_tdo_low_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !sel |-> !tdo);
endmodule

// File: rtl/jtag_dbgreg_sync.sv
module jtag_dbgreg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] ff_d, ff_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb ff_d = din;
        end else begin : g_many
            always_comb ff_d = {ff_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

    assign dout = ff_q[STAGES-1];
endmodule

// File: rtl/jtag_dbgreg_apply.sv
module jtag_dbgreg_apply
    import jtag_dbgreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tgl_sync,
    input  xfer_t            xfer,
    input  logic [REG_W-1:0] core_reg,
    input  logic [REG_W-1:0] wr_mask,
    output logic             reg_wr_en,
    output logic [REG_W-1:0] reg_wr_data,
    output logic             dbg_break,
    output logic             hold_reset
);
    typedef struct packed {
        logic             seen;
        logic             wr_en;
        logic [REG_W-1:0] wr_data;
        logic             brk;
        logic             hold;
    } core_state_t;

    core_state_t cs_d, cs_q;
    logic        apply;

    assign apply = tgl_sync ^ cs_q.seen;

    always_comb begin
        cs_d       = cs_q;
        cs_d.seen  = tgl_sync;
        cs_d.wr_en = 1'b0;
        cs_d.brk   = 1'b0;
        if (apply) begin
            cs_d.hold  = xfer.hold;
            cs_d.brk   = xfer.brk;
            cs_d.wr_en = xfer.wr;
            if (xfer.wr)
                cs_d.wr_data = (xfer.image & wr_mask) | (core_reg & ~wr_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign reg_wr_en   = cs_q.wr_en;
    assign reg_wr_data = cs_q.wr_data;
    assign dbg_break   = cs_q.brk;
    assign hold_reset  = cs_q.hold;

    // R5
    break_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_break |=> !dbg_break);
    // R4
    write_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);
    // R4
    masked_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (((reg_wr_data ^ $past(core_reg)) & ~$past(wr_mask)) == '0));
    // R6
    hold_only_on_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(hold_reset));
endmodule

// File: rtl/jtag_dbgreg_access.sv
module jtag_dbgreg_access
    import jtag_dbgreg_pkg::*;
#(
    parameter int IR_W        = 5,
    parameter logic [IR_W-1:0] SEL_OPCODE = 5'b01001,
    parameter int SYNC_STAGES = 2
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tap_tlr,
    input  logic [IR_W-1:0]  ir_value,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             tdi,
    output logic             tdo,
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] core_reg,
    input  logic [REG_W-1:0] wr_mask,
    output logic             reg_wr_en,
    output logic [REG_W-1:0] reg_wr_data,
    output logic             dbg_break,
    output logic             hold_reset
);
    xfer_t xfer;
    logic  xfer_tgl;
    logic  tgl_sync;

    jtag_dbgreg_chain #(.IR_W(IR_W), .SEL_OPCODE(SEL_OPCODE)) u_chain (
        .tck(tck), .trst_n(trst_n), .tap_tlr(tap_tlr), .ir_value(ir_value),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .core_reg(core_reg),
        .xfer(xfer), .xfer_tgl(xfer_tgl)
    );

    jtag_dbgreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(xfer_tgl), .dout(tgl_sync)
    );

    jtag_dbgreg_apply u_apply (
        .clk(clk), .rst_n(rst_n), .tgl_sync(tgl_sync), .xfer(xfer),
        .core_reg(core_reg), .wr_mask(wr_mask),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .dbg_break(dbg_break), .hold_reset(hold_reset)
    );
endmodule

// File: tb/jtag_dbgreg_access_test.sv
module jtag_dbgreg_access_test;
    logic        tck = 0, trst_n = 0, tap_tlr = 0;
    logic [4:0]  ir_value = 5'b01001;
    logic        capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic        tdo;
    logic        clk = 0, rst_n = 0;
    logic [31:0] core_reg = 0, wr_mask = 0;
    logic        reg_wr_en, dbg_break, hold_reset;
    logic [31:0] reg_wr_data;

    int errors = 0, checks = 0;
    int n_wr = 0, n_brk = 0;
    logic [31:0] last_wr = 0;
    logic [35:0] dout;
    bit   done = 0;

    jtag_dbgreg_access uut (
        .tck(tck), .trst_n(trst_n), .tap_tlr(tap_tlr), .ir_value(ir_value),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .clk(clk), .rst_n(rst_n),
        .core_reg(core_reg), .wr_mask(wr_mask), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .dbg_break(dbg_break), .hold_reset(hold_reset)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (reg_wr_en) begin n_wr++; last_wr = reg_wr_data; end
        if (dbg_break) n_brk++;
    end

    function automatic logic [35:0] exp_capture(input logic [31:0] r);
        return {1'b1, r, 3'b000};
    endfunction
    function automatic logic [31:0] exp_merge(input logic [31:0] img, r, m);
        return (img & m) | (r & ~m);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tck_cycle();
        #20 tck = 1;
        #20 tck = 0;
    endtask

    task automatic scan(input logic [35:0] din, output logic [35:0] dq);
        capture_dr = 1; tck_cycle(); capture_dr = 0;
        shift_dr = 1;
        for (int i = 0; i < 36; i++) begin
            tdi = din[i];
            #10 dq[i] = tdo;
            #10 tck = 1;
            #20 tck = 0;
        end
        shift_dr = 0;
        update_dr = 1; tck_cycle(); update_dr = 0;
        repeat (25) @(posedge clk);
        #1;
    endtask

    initial begin
        #150000;
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] img, m, r;
        logic        b, h;
        void'($urandom(32'd4242));
        #30 trst_n = 1; rst_n = 1;
        #10;
        // R9 reset state
        chk("R9", {tdo, reg_wr_en, dbg_break, hold_reset}, 4'b0000);

        // R2 R3 R4 R5 R6: directed, full mask, break and hold set
        core_reg = 32'hA5A5_0F0F; wr_mask = 32'hFFFF_FFFF;
        n_wr = 0; n_brk = 0;
        scan({1'b0, 32'h1234_5678, 1'b1, 1'b1, 1'b0}, dout);
        chk("R2", dout, exp_capture(32'hA5A5_0F0F));
        chk("R4", {n_wr, last_wr}, {32'd1, 32'h1234_5678});
        chk("R5", n_brk, 1);
        chk("R6", hold_reset, 1);

        // R6 level persists across an update that keeps it, R5 no break
        n_wr = 0; n_brk = 0; wr_mask = 32'h0;
        scan({1'b1, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1}, dout);
        chk("R6", hold_reset, 1);
        chk("R5", n_brk, 0);
        // R4 zero mask keeps core value; R7 bits 35 and 0 ignored
        chk("R7", last_wr, core_reg);

        // R1 non-matching opcode: nothing happens, tdo low
        ir_value = 5'b01000; n_wr = 0; n_brk = 0;
        scan({1'b1, 32'h0, 1'b1, 1'b0, 1'b1}, dout);
        chk("R1", {dout, n_wr[3:0], n_brk[3:0], hold_reset}, {36'h0, 4'd0, 4'd0, 1'b1});
        ir_value = 5'b01001;

        // R8 test-logic-reset clears hold
        n_wr = 0; n_brk = 0;
        tap_tlr = 1; tck_cycle(); tap_tlr = 0;
        repeat (25) @(posedge clk); #1;
        chk("R8", {hold_reset, n_wr[3:0], n_brk[3:0]}, 9'h0);

        // R6 hold set then cleared by a later update
        scan({1'b0, 32'h0, 1'b0, 1'b1, 1'b0}, dout);
        chk("R6", hold_reset, 1);
        scan({1'b0, 32'h0, 1'b0, 1'b0, 1'b0}, dout);
        chk("R6", hold_reset, 0);

        // R3 R4 R5 R6 R7 random patterns
        for (int k = 0; k < 30; k++) begin
            r = $urandom; m = $urandom; img = $urandom;
            b = 1'($urandom); h = 1'($urandom);
            core_reg = r; wr_mask = m; n_wr = 0; n_brk = 0;
            scan({1'($urandom), img, b, h, 1'($urandom)}, dout);
            chk("R3", dout, exp_capture(r));
            chk("R4", {n_wr, last_wr}, {32'd1, exp_merge(img, r, m)});
            chk("R5", n_brk, {31'd0, b});
            chk("R6", hold_reset, h);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule